// File: doc/BRIEF.md
# Table-Driven APB Register Loader

After power-up, this block writes a fixed list of configuration values into a peripheral's register space, for example a serial transceiver that must be set up before it can carry traffic. It is the bus master of a 32-bit APB segment. No processor or firmware is involved: two constant tables, one of register addresses and one of data words, are stepped through with a shared index, and each index produces exactly one APB write.

The sequencer fetches entry *i* from both tables and drives a setup phase, then an access phase. It waits in the access phase until the slave signals ready. The bus then returns to idle before the next entry starts. A slave error response sets a sticky error flag, but the walk through the table does not stop. After the final entry, `done` goes high and stays high, and the bus stays idle until the next reset. The table length and contents are parameters. The default is a short four-entry test table.

Top module: `cfg_apb_loader`

## Requirements
- R1: For entry i, the address driven on `apb_paddr` is bits [32i+31:32i] of `ADDR_TABLE`, and the data driven on `apb_pwdata` is bits [32i+31:32i] of `DATA_TABLE`. Both buses are 32 bits wide.
- R2: Each of the `N_ENTRY` entries is written exactly once, in ascending index order starting at entry 0.
- R3: During every transfer, `apb_pwrite` is 1 and `apb_pstrb` is 4'b1111.
- R4: Every transfer starts with one cycle in which `apb_psel`=1 and `apb_penable`=0. The following cycle has both signals at 1. `apb_penable` is never 1 while `apb_psel` is 0.
- R5: While `apb_pready` is 0 in the access phase, the master holds `apb_psel`, `apb_penable`, `apb_paddr` and `apb_pwdata` unchanged. In the cycle after the access cycle that has `apb_pready`=1, `apb_psel` and `apb_penable` are both 0.
- R6: There is at least one idle cycle (`apb_psel`=0) between the end of one transfer and the setup cycle of the next.
- R7: If `apb_pslverr` is 1 in a completing access cycle, `err` becomes 1 in the next cycle. It stays 1 until reset, and the remaining entries are still written. If no completing cycle has `apb_pslverr`=1, `err` stays 0.
- R8: `done` becomes 1 in the cycle after the last entry completes. It then stays 1 with `apb_psel`=0 until reset, and no further transfer starts.
- R9: While `rst` is 1 (synchronous, active high), `apb_psel`, `apb_penable`, `done` and `err` are all 0. Once `rst` is released, the table restarts from entry 0, even if reset was applied in the middle of the sequence.
- R10: An error response on the last entry makes `err` and `done` rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| apb_paddr | output | 32 | Register address |
| apb_psel | output | 1 | Slave select |
| apb_penable | output | 1 | Access-phase strobe |
| apb_pwrite | output | 1 | Write direction, always 1 |
| apb_pwdata | output | 32 | Write data |
| apb_pstrb | output | 4 | Byte strobes, always all ones |
| apb_pready | input | 1 | Slave ready, ends the access phase |
| apb_pslverr | input | 1 | Slave error, sampled when ready |
| done | output | 1 | Whole table written, sticky |
| err | output | 1 | At least one error response seen, sticky |

## Verification
The completion of the final transfer and the capture of a slave error can land on the same clock edge. In that case the error flag and the done flag must both rise together. The bench provokes this with an error mask that flags the last table entry, combined with wait states. At the first sample where `done` is high, it checks that `err` is also already high. Other masks place errors on the first and middle entries. These cases confirm that the error flag becomes sticky and that the remaining entries are still written.

// File: rtl/cfg_apb_pkg.sv
package cfg_apb_pkg;
  localparam int APB_W = 32;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LOAD,
    ST_SETUP,
    ST_ACCESS,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/cfg_table_rom.sv
module cfg_table_rom #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 32,
  parameter logic [DEPTH*WIDTH-1:0] TABLE = '0,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  output logic [WIDTH-1:0] q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = TABLE[i*WIDTH +: WIDTH];
  end

  // registered read port, block-RAM style
  always_ff @(posedge clk) begin
    if (idx <= LAST) q <= mem[idx];
    else             q <= '0;
  end
endmodule

// File: rtl/cfg_apb_seq.sv
module cfg_apb_seq
  import cfg_apb_pkg::*;
#(
  parameter int N_ENTRY = 4,
  localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [APB_W-1:0] rom_addr,
  input  logic [APB_W-1:0] rom_data,
  output logic [IDX_W-1:0] idx,
  output logic [APB_W-1:0] paddr,
  output logic [APB_W-1:0] pwdata,
  output logic             psel,
  output logic             penable,
  input  logic             pready,
  input  logic             pslverr,
  output logic             done,
  output logic             err
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRY - 1);

  seq_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_FETCH;
      idx     <= '0;
      paddr   <= '0;
      pwdata  <= '0;
      psel    <= 1'b0;
      penable <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      case (st)
        ST_FETCH: st <= ST_LOAD;          // ROM read of idx in flight
        ST_LOAD: begin
          paddr  <= rom_addr;
          pwdata <= rom_data;
          psel   <= 1'b1;
          st     <= ST_SETUP;
        end
        ST_SETUP: begin
          penable <= 1'b1;
          st      <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (pready) begin
            psel    <= 1'b0;
            penable <= 1'b0;
            if (pslverr) err <= 1'b1;
            if (idx == LAST) begin
              done <= 1'b1;
              st   <= ST_DONE;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_FETCH;
            end
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  // R4: setup cycle is always followed by an access cycle
  a_r4_setup_then_access: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable));
  // R4: no enable without select
  a_r4_enable_needs_sel: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel);
  // R5: wait states hold the transfer
  a_r5_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=>
      (psel && penable && $stable(paddr) && $stable(pwdata)));
  // R5: bus released after completion
  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pready) |=> (!psel && !penable));
  // R7: error flag is sticky
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R8: done is sticky and the bus stays idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !psel));
endmodule

// File: rtl/cfg_apb_loader.sv
module cfg_apb_loader
  import cfg_apb_pkg::*;
#(
  parameter int N_ENTRY = 4,
  parameter logic [N_ENTRY*APB_W-1:0] ADDR_TABLE =
    {32'h0000_200C, 32'h0000_2008, 32'h0000_2004, 32'h0000_2000},
  parameter logic [N_ENTRY*APB_W-1:0] DATA_TABLE =
    {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000}
) (
  input  logic             clk,
  input  logic             rst,
  output logic [APB_W-1:0] apb_paddr,
  output logic             apb_psel,
  output logic             apb_penable,
  output logic             apb_pwrite,
  output logic [APB_W-1:0] apb_pwdata,
  output logic [APB_W/8-1:0] apb_pstrb,
  input  logic             apb_pready,
  input  logic             apb_pslverr,
  output logic             done,
  output logic             err
);
  localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

  logic [IDX_W-1:0] idx;
  logic [APB_W-1:0] rom_addr;
  logic [APB_W-1:0] rom_data;

  cfg_table_rom #(.DEPTH(N_ENTRY), .WIDTH(APB_W), .TABLE(ADDR_TABLE)) i_addr_rom (
    .clk(clk), .idx(idx), .q(rom_addr)
  );

  cfg_table_rom #(.DEPTH(N_ENTRY), .WIDTH(APB_W), .TABLE(DATA_TABLE)) i_data_rom (
    .clk(clk), .idx(idx), .q(rom_data)
  );

  cfg_apb_seq #(.N_ENTRY(N_ENTRY)) i_seq (
    .clk     (clk),
    .rst     (rst),
    .rom_addr(rom_addr),
    .rom_data(rom_data),
    .idx     (idx),
    .paddr   (apb_paddr),
    .pwdata  (apb_pwdata),
    .psel    (apb_psel),
    .penable (apb_penable),
    .pready  (apb_pready),
    .pslverr (apb_pslverr),
    .done    (done),
    .err     (err)
  );

  assign apb_pwrite = 1'b1;
  assign apb_pstrb  = '1;
endmodule

// File: tb/test_cfg_apb_loader.sv
module test_cfg_apb_loader;
  localparam int N = 5;
  localparam logic [N*32-1:0] T_ADDR =
    {32'h0000_0A40, 32'h0000_0A30, 32'h0000_0A20, 32'h0000_0A10, 32'h0000_0A00};
  localparam logic [N*32-1:0] T_DATA =
    {32'h5A5A_0004, 32'h1234_5678, 32'hFFFF_0000, 32'h0000_FFFF, 32'hDEAD_BEEF};
  localparam int NSCEN = 4;
  localparam int WAITS [NSCEN] = '{0, 2, 1, 3};
  localparam logic [N-1:0] MASKS [NSCEN] = '{5'b00000, 5'b00010, 5'b10000, 5'b00101};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] apb_paddr, apb_pwdata;
  logic apb_psel, apb_penable, apb_pwrite, apb_pready, apb_pslverr, done, err;
  logic [3:0] apb_pstrb;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  cfg_apb_loader #(.N_ENTRY(N), .ADDR_TABLE(T_ADDR), .DATA_TABLE(T_DATA)) i_cfg_apb_loader (
    .clk(clk), .rst(rst),
    .apb_paddr(apb_paddr), .apb_psel(apb_psel), .apb_penable(apb_penable),
    .apb_pwrite(apb_pwrite), .apb_pwdata(apb_pwdata), .apb_pstrb(apb_pstrb),
    .apb_pready(apb_pready), .apb_pslverr(apb_pslverr),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // abort_after > 0: stop after that many writes (for the mid-run reset test)
  task automatic run(input int waits, input logic [N-1:0] mask, input int abort_after);
    int nwr = 0, wc = 0, cyc = 0;
    bit prev_psel = 0, prev_pen = 0, prev_cmpl = 0, pend_err = 0, err_exp = 0;
    logic [31:0] hold_a = '0, hold_d = '0;
    rst = 1'b1; apb_pready = 1'b0; apb_pslverr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!apb_psel && !apb_penable && !done && !err, "R9 reset state",
          {28'd0, apb_psel, apb_penable, done, err}, 32'd0);
    rst = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 2000) begin
        check(1'b0, "watchdog", 32'(nwr), 32'(N));
        break;
      end
      if (pend_err) err_exp = 1;
      pend_err = 0;
      if (err !== err_exp) check(1'b0, "R7 error flag", {31'd0, err}, {31'd0, err_exp});
      if (prev_cmpl)
        check(!apb_psel && !apb_penable, "R5 release after ready",
              {30'd0, apb_psel, apb_penable}, 32'd0);
      if (done) begin
        check(nwr == N && prev_cmpl, "R8 done after last entry", 32'(nwr), 32'(N));
        if (mask[N-1]) check(err === 1'b1, "R10 err with done", {31'd0, err}, 32'd1);
        apb_pready = 1'b1;
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          if (!done || apb_psel) check(1'b0, "R8 done sticky, bus idle",
                                       {30'd0, done, apb_psel}, 32'd2);
        end
        check(done && !apb_psel && err === err_exp, "R8 final state",
              {30'd0, done, err}, {30'd1, err_exp, 1'b0} >> 0);
        apb_pready = 1'b0;
        break;
      end
      if (apb_penable && !apb_psel) check(1'b0, "R4 enable without select", 32'd1, 32'd0);
      if (apb_psel && !apb_penable)
        check(!prev_psel, "R6 idle before setup", {31'd0, prev_psel}, 32'd0);
      prev_cmpl = 0;
      if (apb_psel && apb_penable) begin
        if (wc == 0) check(prev_psel && !prev_pen, "R4 setup before access",
                           {30'd0, prev_psel, prev_pen}, 32'd2);
        else check(apb_paddr == hold_a && apb_pwdata == hold_d, "R5 hold on wait",
                   apb_paddr, hold_a);
        hold_a = apb_paddr; hold_d = apb_pwdata;
        if (wc < waits) begin
          apb_pready = 1'b0; apb_pslverr = 1'b0; wc++;
        end else begin
          apb_pready = 1'b1; apb_pslverr = mask[nwr];
          check(nwr < N, "R2 write count", 32'(nwr), 32'(N - 1));
          if (nwr < N) begin
            check(apb_paddr == T_ADDR[nwr*32 +: 32], "R1/R2 address", apb_paddr, T_ADDR[nwr*32 +: 32]);
            check(apb_pwdata == T_DATA[nwr*32 +: 32], "R1 data", apb_pwdata, T_DATA[nwr*32 +: 32]);
          end
          check(apb_pwrite && apb_pstrb == 4'hF, "R3 write and strobes",
                {27'd0, apb_pwrite, apb_pstrb}, 32'h1F);
          if (mask[nwr]) pend_err = 1;
          nwr++; wc = 0; prev_cmpl = 1;
        end
      end else begin
        apb_pready = 1'b0; apb_pslverr = 1'b0;
      end
      prev_psel = apb_psel; prev_pen = apb_penable;
      if (abort_after > 0 && nwr == abort_after && !prev_cmpl) break;
    end
  endtask

  initial begin
    apb_pready = 1'b0; apb_pslverr = 1'b0;
    for (int s = 0; s < NSCEN; s++) run(WAITS[s], MASKS[s], 0);
    // R9: reset in mid-sequence after an error, then a full clean run from entry 0
    run(1, 5'b00001, 2);
    check(err === 1'b1, "R7 err set before reset", {31'd0, err}, 32'd1);
    run(0, 5'b00000, 0);
    // R10 again with no wait states
    run(0, 5'b10000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule